// File: doc/BRIEF.md
# Serial Pattern Pulse Train Channel

This block is one output channel of a pulse train generator. It emits a programmed pattern word one bit at a time, least significant bit first. Each bit lasts a programmable number of ticks from a shared prescaler. The pattern can be replayed a fixed number of times or without end. A programmable number of idle, low bit periods separates consecutive replays. When a finite run ends, the channel produces a one-cycle loop-exit pulse that other channels can use as a trigger. It also drops its running state and raises a done flag.

A second mode replaces the pattern with a square wave of 50% duty. Its half-period is one bit period, so the same rate divisor sets the frequency. All configuration inputs are expected to stay steady while the channel runs. Raising the enable input starts a fresh run, and lowering it stops the channel at once.

Top module: `ptrain_channel`

## Requirements
- R1: The pattern leaves on `wave_o` least significant bit first. Each bit lasts `rate_div_i`+1 tick pulses, counted from the cycle after the start.
- R2: A length code of 0 sends all 32 pattern bits per replay. A code N in 2..31 sends exactly bits 0..N-1.
- R3: A length code of 1 is treated as 2, so bits 0 and 1 are sent.
- R4: With a nonzero loop count L, the pattern is sent L times. In the cycle after the last bit period ends, `loop_exit_o` is high for exactly one cycle, `running_o` is low and `done_o` is high. `done_o` stays high afterwards.
- R5: With a loop count of 0, the pattern repeats for as long as the channel is enabled, and `loop_exit_o` never rises.
- R6: Between two consecutive replays, `wave_o` stays low for `loop_dly_i` bit periods. No gap follows the final replay.
- R7: Without a tick pulse the channel does not advance, and `wave_o` holds its level.
- R8: One cycle after `enable_i` is sampled low, `running_o` and `wave_o` are low.
- R9: A rising edge on `enable_i` restarts the channel from pattern bit 0 with the loop count reloaded. In the very next cycle `done_o` is low and `running_o` is high.
- R10: With `sqw_mode_i` high, `wave_o` starts high and toggles at the end of every bit period. The loop count and delay have no effect, and `loop_exit_o` stays low.
- R11: After reset, `wave_o`, `loop_exit_o`, `running_o` and `done_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Clock-enable pulse from the shared prescaler |
| enable_i | input | 1 | Run enable; a rising edge starts a run |
| sqw_mode_i | input | 1 | 1 selects the square wave, 0 the pattern |
| pattern_i | input | 32 | Pattern word, bit 0 sent first |
| len_code_i | input | 5 | Length code: 0 = 32 bits, 1 = 2 bits, N = N bits |
| loop_cnt_i | input | 16 | Number of replays, 0 = endless |
| loop_dly_i | input | 16 | Idle bit periods between replays |
| rate_div_i | input | 16 | Bit period minus one, in ticks |
| wave_o | output | 1 | Serial output |
| loop_exit_o | output | 1 | One-cycle pulse when a finite run completes |
| running_o | output | 1 | Channel is emitting or inside a gap |
| done_o | output | 1 | Last finite run has completed |

## Verification
The assertions check several rules on every cycle. The loop-exit pulse is a single cycle and coincides with done high and running low. Done never overlaps running. The output is low whenever the channel is not running, and a sampled-low enable always stops the channel. A running channel holds its output across a cycle without a tick. In square-wave mode a loop exit never occurs.

Only the bench scenarios can show the actual bit order, the length decoding including the illegal code, and the replay count. The same holds for the width of the idle gap, the square-wave phase and restart from bit 0. For these, the bench compares each sampled output against a stream it builds arithmetically from the configuration.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SHIFT = 2'd1,
        PH_GAP   = 2'd2
    } ptc_phase_e;

endpackage

// File: rtl/ptc_rate_div.sv
// Counts prescaler ticks and flags the last tick of each bit period.
module ptc_rate_div #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             tick_i,
    input  logic [DIV_W-1:0] limit_i,
    output logic             bit_end_o
);

    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (tick_i) begin
            if (cnt_q == limit_i) begin
                cnt_d = '0;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign bit_end_o = !clear_i && tick_i && (cnt_q == limit_i);

endmodule

// File: rtl/ptc_len_decode.sv
// Turns the length code into the index of the last bit sent per replay.
module ptc_len_decode #(
    parameter int PAT_W = 32,
    localparam int LEN_W = $clog2(PAT_W)
) (
    input  logic [LEN_W-1:0] code_i,
    output logic [LEN_W-1:0] last_idx_o
);

    localparam logic [LEN_W-1:0] FULL_LAST = LEN_W'(PAT_W - 1);
    localparam logic [LEN_W-1:0] MIN_LAST  = LEN_W'(1);

    always_comb begin
        if (code_i == '0) begin
            last_idx_o = FULL_LAST;
        end else if (code_i == LEN_W'(1)) begin
            last_idx_o = MIN_LAST;          // illegal code 1 widened to two bits
        end else begin
            last_idx_o = code_i - 1'b1;
        end
    end

endmodule

// File: rtl/ptrain_channel.sv
module ptrain_channel #(
    parameter int PAT_W  = 32,
    parameter int LOOP_W = 16,
    parameter int DLY_W  = 16,
    parameter int DIV_W  = 16,
    localparam int LEN_W = $clog2(PAT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              enable_i,
    input  logic              sqw_mode_i,
    input  logic [PAT_W-1:0]  pattern_i,
    input  logic [LEN_W-1:0]  len_code_i,
    input  logic [LOOP_W-1:0] loop_cnt_i,
    input  logic [DLY_W-1:0]  loop_dly_i,
    input  logic [DIV_W-1:0]  rate_div_i,
    output logic              wave_o,
    output logic              loop_exit_o,
    output logic              running_o,
    output logic              done_o
);

    import ptc_pkg::*;

    typedef struct packed {
        ptc_phase_e        phase;
        logic [LEN_W-1:0]  idx;
        logic [LOOP_W-1:0] loops;
        logic [DLY_W-1:0]  gapc;
        logic              sq;
        logic              ex;
        logic              done;
        logic              en;
    } ptc_state_t;

    ptc_state_t st_d, st_q;

    logic             start;
    logic             div_clear;
    logic             bit_end;
    logic [LEN_W-1:0] last_idx;
    logic             finite;
    logic             final_pass;

    assign start     = enable_i && !st_q.en;
    assign div_clear = start || (st_q.phase == PH_IDLE);
    assign finite    = (loop_cnt_i != '0);
    assign final_pass = finite && (st_q.loops == LOOP_W'(1));

    ptc_rate_div #(.DIV_W(DIV_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (div_clear),
        .tick_i    (tick_i),
        .limit_i   (rate_div_i),
        .bit_end_o (bit_end)
    );

    ptc_len_decode #(.PAT_W(PAT_W)) u_len (
        .code_i     (len_code_i),
        .last_idx_o (last_idx)
    );

    always_comb begin
        st_d    = st_q;
        st_d.en = enable_i;
        st_d.ex = 1'b0;
        if (!enable_i) begin
            st_d.phase = PH_IDLE;
        end else if (start) begin
            st_d.phase = PH_SHIFT;
            st_d.idx   = '0;
            st_d.loops = loop_cnt_i;
            st_d.gapc  = '0;
            st_d.sq    = 1'b1;
            st_d.done  = 1'b0;
        end else if (bit_end) begin
            if (sqw_mode_i) begin
                st_d.sq = !st_q.sq;
            end else if (st_q.phase == PH_SHIFT) begin
                if (st_q.idx == last_idx) begin
                    if (final_pass) begin
                        st_d.phase = PH_IDLE;
                        st_d.ex    = 1'b1;
                        st_d.done  = 1'b1;
                    end else begin
                        if (finite) begin
                            st_d.loops = st_q.loops - 1'b1;
                        end
                        st_d.idx = '0;
                        if (loop_dly_i != '0) begin
                            st_d.phase = PH_GAP;
                            st_d.gapc  = '0;
                        end
                    end
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                end
            end else if (st_q.phase == PH_GAP) begin
                if (st_q.gapc == loop_dly_i - 1'b1) begin
                    st_d.phase = PH_SHIFT;
                    st_d.gapc  = '0;
                end else begin
                    st_d.gapc = st_q.gapc + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, idx: '0, loops: '0, gapc: '0,
                      sq: 1'b0, ex: 1'b0, done: 1'b0, en: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign running_o   = (st_q.phase != PH_IDLE);
    assign loop_exit_o = st_q.ex;
    assign done_o      = st_q.done;
    assign wave_o      = (st_q.phase == PH_SHIFT) &&
                         (sqw_mode_i ? st_q.sq : pattern_i[st_q.idx]);

endmodule

// File: rtl/ptc_checker.sv
module ptc_checker (
    input logic clk,
    input logic rst_n,
    input logic tick_i,
    input logic enable_i,
    input logic sqw_mode_i,
    input logic wave_o,
    input logic loop_exit_o,
    input logic running_o,
    input logic done_o
);

    assert_exit_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        loop_exit_o |=> !loop_exit_o);

    assert_exit_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
        loop_exit_o |-> (done_o && !running_o));

    assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !running_o);

    assert_idle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !running_o |-> !wave_o);

    assert_disable_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> !running_o);

    assert_hold_no_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && enable_i && !tick_i) |=> $stable(wave_o));

    assert_sq_no_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sqw_mode_i && running_o) |=> !loop_exit_o);

endmodule

bind ptrain_channel ptc_checker u_chk (.*);

// File: tb/sim_ptrain_channel.sv
module sim_ptrain_channel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        enable_i = 1'b0;
    logic        sqw_mode_i = 1'b0;
    logic [31:0] pattern_i = '0;
    logic [4:0]  len_code_i = '0;
    logic [15:0] loop_cnt_i = '0;
    logic [15:0] loop_dly_i = '0;
    logic [15:0] rate_div_i = '0;
    logic        wave_o, loop_exit_o, running_o, done_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #4 clk = !clk;   // 125 MHz

    ptrain_channel u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .enable_i(enable_i),
        .sqw_mode_i(sqw_mode_i), .pattern_i(pattern_i), .len_code_i(len_code_i),
        .loop_cnt_i(loop_cnt_i), .loop_dly_i(loop_dly_i), .rate_div_i(rate_div_i),
        .wave_o(wave_o), .loop_exit_o(loop_exit_o), .running_o(running_o),
        .done_o(done_o)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    // Runs one configuration from a fresh enable edge and compares every cycle.
    task automatic run_case(input logic [31:0] pat, input int code, input int loops,
                            input int dly, input int div, input int tp, input bit sqw,
                            input int ncyc, input string wreq);
        int  nb, per, tot, ticks, j, pos, fin_cnt;
        bit  fin, tprev, ew, ex, er, ed;
        bit  werr, serr, r9err;
        int  wa, we, sa, se;
        string wtag;
        nb   = (code == 0) ? 32 : ((code == 1) ? 2 : code);
        per  = nb + dly;
        tot  = loops * per - dly;
        ticks = 0; fin = 0; fin_cnt = 0; tprev = 0;
        werr = 0; serr = 0; r9err = 0; wa = 0; we = 0; sa = 0; se = 0;
        wtag = wreq;
        @(negedge clk);
        pattern_i = pat; len_code_i = 5'(code); loop_cnt_i = 16'(loops);
        loop_dly_i = 16'(dly); rate_div_i = 16'(div); sqw_mode_i = sqw;
        enable_i = 1'b1; tick_i = 1'b0;
        for (int k = 0; k < ncyc; k++) begin
            @(negedge clk);
            if (k > 0 && tprev && !fin) ticks++;
            j  = ticks / (div + 1);
            ex = 0;
            if (!sqw && loops != 0 && !fin && j == tot) begin
                fin = 1; ex = 1;
            end
            er = !fin;
            ed = fin;
            if (fin) ew = 0;
            else if (sqw) ew = ((j % 2) == 0);
            else begin
                pos = j % per;
                ew  = (pos < nb) ? pat[pos] : 1'b0;
            end
            if (wave_o !== ew && !werr) begin
                werr = 1; wa = int'(wave_o); we = int'(ew);
                if (!sqw && !fin && (j % per) >= nb) wtag = "R6";
            end
            if ({loop_exit_o, running_o, done_o} !== {ex, er, ed} && !serr) begin
                serr = 1;
                sa = int'({loop_exit_o, running_o, done_o});
                se = int'({ex, er, ed});
            end
            if (k == 0 && (done_o !== 1'b0 || running_o !== 1'b1)) r9err = 1;
            if (fin) begin
                fin_cnt++;
                if (fin_cnt > 3) break;
            end
            tprev  = (tp > 0) && ((k % tp) == 0);
            tick_i = tprev;
        end
        chk(!werr, wtag, "wave", wa, we);
        chk(!serr, (loops == 0 || sqw) ? (sqw ? "R10" : "R5") : "R4",
            "exit/run/done", sa, se);
        chk(!r9err, "R9", "restart state", int'({running_o, done_o}), 2);
        @(negedge clk);
        enable_i = 1'b0; tick_i = 1'b0;
        @(negedge clk);
        chk(!running_o && !wave_o && !loop_exit_o, "R8", "disabled",
            int'({running_o, wave_o, loop_exit_o}), 0);
    endtask

    initial begin
        int idx;
        int codes[5];
        logic [31:0] pats[2];
        codes = '{0, 1, 2, 3, 7};
        pats  = '{32'hB4E1_96C3, 32'h0F0F_A5A1};
        repeat (3) @(negedge clk);
        // R11: reset state
        chk({wave_o, loop_exit_o, running_o, done_o} === 4'b0, "R11", "reset",
            int'({wave_o, loop_exit_o, running_o, done_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep: R1 bit order/period, R2 length, R3 code 1, R4 count, R6 gap
        idx = 0;
        for (int p = 0; p < 2; p++)
            for (int c = 0; c < 5; c++)
                for (int l = 1; l <= 3; l++)
                    for (int d = 0; d <= 2; d += 2)
                        for (int v = 0; v <= 1; v++) begin
                            run_case(pats[p], codes[c], l, d, v, 1 + (idx % 2), 1'b0,
                                     2000, (codes[c] == 1) ? "R3" :
                                           ((codes[c] == 0) ? "R2" : "R1"));
                            idx++;
                        end

        // R5: endless replay, no exit
        run_case(32'h0000_0013, 5, 0, 1, 0, 1, 1'b0, 80, "R5");
        // R9: stop mid-run, then a full run of the same setup must restart at bit 0
        run_case(32'h0000_00A6, 8, 2, 1, 0, 1, 1'b0, 7, "R9");
        run_case(32'h0000_00A6, 8, 2, 1, 0, 1, 1'b0, 200, "R9");
        // R7: no ticks, channel frozen on bit 0
        run_case(32'h0000_0001, 4, 1, 0, 0, 0, 1'b0, 30, "R7");
        run_case(32'h0000_0002, 4, 1, 0, 0, 0, 1'b0, 30, "R7");
        // R10: square wave ignores loop count and delay
        run_case(32'h0, 3, 1, 2, 2, 1, 1'b1, 40, "R10");
        run_case(32'h0, 0, 1, 0, 0, 2, 1'b1, 40, "R10");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule